// File: doc/BRIEF.md
# Ring-Cascaded FIFO Slice Controller

This block is one slice of a deep FIFO that is built from several identical slices. The slices sit in a ring and share a write data bus, a write enable and a read enable. A write token and a read token travel around the ring separately. The slice that holds the write token stores incoming words. The slice that holds the read token presents its oldest word and removes it on a read. A slice fills its locations in order. When it uses its last location, it drives a one-cycle active-low pulse on its cascade output, and that pulse gives the token to the next slice in the ring. The read side works the same way, so the ring as a whole gives the words back in the order they were written.

A strap input marks the slice that starts with both tokens. In a ring, exactly one slice has the strap low. A mode input turns the slice into a stand-alone FIFO. In that mode it holds both tokens permanently and its write cascade output carries an active-low half-full flag. The host combines the slices by OR: the ready signals of all slices give the global "can write" and "can read" signals, and the slices' read data buses give the shared output word.

Top module: `fifo_ring_slice`

## Requirements
- R1: During and after reset, a slice with `first_load_n` low holds both tokens and a slice with it high holds none. Both cascade outputs are high and the slice is empty.
- R2: A write is taken only when the slice holds the write token and is not full. A slice holds the token when it owns it or when its `wr_casc_in_n` is low in that cycle. The word goes to the next location in order. `wr_ready` is low on every slice that lacks the token.
- R3: The clock edge that writes location DEPTH-1 in ring mode drives `wr_casc_out_n` low for exactly the following cycle. The slice then gives up the write token.
- R4: The clock edge that reads location DEPTH-1 in ring mode drives `rd_casc_out_n` low for exactly the following cycle. The slice then gives up the read token.
- R5: A low on a cascade input gives the slice its token in that same cycle. Its ready output may rise with no cycle lost.
- R6: `rd_data` is all zeros on any slice that lacks the read token. The token holder shows its oldest stored word.
- R7: N slices in a ring act as one FIFO of DEPTH*N words. Words come out in write order, and the global write-ready falls after DEPTH*N unread words.
- R8: A write while full and a read while empty have no effect on the stored data or on the count.
- R9: With `standalone` high, the slice holds both tokens permanently and its pointers wrap. `wr_casc_out_n` is low exactly when the count is at least DEPTH/2. `rd_casc_out_n` stays high.
- R10: A write and a read in the same cycle on one slice leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| standalone | input | 1 | 1: stand-alone FIFO, 0: ring member |
| first_load_n | input | 1 | Low on the one slice that starts with the tokens |
| wr_en | input | 1 | Shared write request |
| wr_data | input | WIDTH | Shared write word |
| wr_ready | output | 1 | This slice would take a write now |
| rd_en | input | 1 | Shared read request |
| rd_data | output | WIDTH | Oldest word when holding read token, else zero |
| rd_ready | output | 1 | This slice would supply a read now |
| wr_casc_in_n | input | 1 | Write token pulse from previous slice |
| wr_casc_out_n | output | 1 | Write token pulse to next slice, or half-full flag in stand-alone mode |
| rd_casc_in_n | input | 1 | Read token pulse from previous slice |
| rd_casc_out_n | output | 1 | Read token pulse to next slice |

## Verification
The properties assume that the mode input does not change after reset. They assume a ring in which exactly one slice has the strap low, so a slice never gets a token pulse while it already holds that token. The bench builds a ring of three slices from a single strap-low member and a separate stand-alone slice, and keeps `standalone` fixed on each. Its reads and writes depend only on the ORed ready signals, but it also asserts enables on full and empty rings on purpose, because the slices must ignore those requests.

// File: rtl/fifo_ring_pkg.sv
package fifo_ring_pkg;
  typedef enum logic {
    SLICE_RING = 1'b0,
    SLICE_SOLO = 1'b1
  } slice_mode_e;
endpackage

// File: rtl/ring_cursor.sv
// Token ownership and location pointer for one direction (write or read).
module ring_cursor #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          first_load_n,
  input  logic          solo,
  input  logic          pass_in_n,
  input  logic          step,
  output logic          hold,
  output logic [AW-1:0] ptr,
  output logic          handoff
);
  logic          tok_q;
  logic [AW-1:0] ptr_q;
  logic          at_last;

  assign at_last = (ptr_q == AW'(DEPTH - 1));
  assign hold    = solo | tok_q | ~pass_in_n;
  assign handoff = step & at_last & ~solo;
  assign ptr     = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_q <= ~first_load_n;
      ptr_q <= '0;
    end else begin
      tok_q <= (tok_q | ~pass_in_n) & ~handoff;
      if (step) ptr_q <= at_last ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/slice_level.sv
// Occupancy counter with empty/full and a registered active-low half flag.
module slice_level #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          empty,
  output logic          full,
  output logic          half_n
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          half_n_q;

  assign cnt_nxt = cnt_q + CW'(inc) - CW'(dec);
  assign cnt     = cnt_q;
  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign half_n  = half_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      half_n_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_nxt;
      half_n_q <= ~(cnt_nxt >= CW'(HALF));
    end
  end
endmodule

// File: rtl/slice_store.sv
// Storage array: synchronous write, asynchronous read of the head word.
module slice_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 18,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_ring_slice.sv
module fifo_ring_slice
  import fifo_ring_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 18,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             standalone,
  input  logic             first_load_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_ready,
  input  logic             wr_casc_in_n,
  output logic             wr_casc_out_n,
  input  logic             rd_casc_in_n,
  output logic             rd_casc_out_n
);
  slice_mode_e      mode;
  logic             solo;
  logic             wr_hold, rd_hold, wr_fire, rd_fire;
  logic             wr_hand, rd_hand;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    lvl_cnt;
  logic             lvl_empty, lvl_full, lvl_half_n;
  logic [WIDTH-1:0] head;
  logic             wr_pass_q, rd_pass_q;

  assign mode = slice_mode_e'(standalone);
  assign solo = (mode == SLICE_SOLO);

  assign wr_ready = wr_hold & ~lvl_full;
  assign rd_ready = rd_hold & ~lvl_empty;
  assign wr_fire  = wr_en & wr_ready;
  assign rd_fire  = rd_en & rd_ready;

  ring_cursor #(.DEPTH(DEPTH)) u_wr_cur (
    .clk(clk), .rst(rst), .first_load_n(first_load_n), .solo(solo),
    .pass_in_n(wr_casc_in_n), .step(wr_fire),
    .hold(wr_hold), .ptr(wr_ptr), .handoff(wr_hand)
  );

  ring_cursor #(.DEPTH(DEPTH)) u_rd_cur (
    .clk(clk), .rst(rst), .first_load_n(first_load_n), .solo(solo),
    .pass_in_n(rd_casc_in_n), .step(rd_fire),
    .hold(rd_hold), .ptr(rd_ptr), .handoff(rd_hand)
  );

  slice_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .inc(wr_fire), .dec(rd_fire),
    .cnt(lvl_cnt), .empty(lvl_empty), .full(lvl_full), .half_n(lvl_half_n)
  );

  slice_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .we(wr_fire), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(rd_ptr), .rdata(head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pass_q <= 1'b1;
      rd_pass_q <= 1'b1;
    end else begin
      wr_pass_q <= ~wr_hand;
      rd_pass_q <= ~rd_hand;
    end
  end

  assign wr_casc_out_n = solo ? lvl_half_n : wr_pass_q;
  assign rd_casc_out_n = rd_pass_q;
  assign rd_data       = rd_hold ? head : '0;
endmodule

// File: rtl/fifo_ring_slice_chk.sv
module fifo_ring_slice_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 18,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             standalone,
  input logic             wr_en,
  input logic             rd_en,
  input logic             wr_ready,
  input logic             rd_ready,
  input logic             wr_casc_out_n,
  input logic             rd_casc_out_n,
  input logic [WIDTH-1:0] rd_data,
  input logic [CW-1:0]    cnt
);
  AST_WR_PULSE_ONE: assert property (@(posedge clk) disable iff (rst || standalone)
    !wr_casc_out_n |=> wr_casc_out_n); // R3
  AST_WR_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst || standalone)
    $fell(wr_casc_out_n) |-> $past(wr_en && wr_ready)); // R3
  AST_RD_PULSE_ONE: assert property (@(posedge clk) disable iff (rst || standalone)
    !rd_casc_out_n |=> rd_casc_out_n); // R4
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst || standalone)
    !rd_casc_out_n |-> (rd_data == '0) && !rd_ready); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) && !(wr_en && wr_ready) |=> cnt == '0); // R8
  AST_SOLO_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    standalone |-> rd_casc_out_n); // R9
  AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_ready && rd_en && rd_ready |=> $stable(cnt)); // R10
endmodule

bind fifo_ring_slice fifo_ring_slice_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .standalone(standalone), .wr_en(wr_en), .rd_en(rd_en),
  .wr_ready(wr_ready), .rd_ready(rd_ready), .wr_casc_out_n(wr_casc_out_n),
  .rd_casc_out_n(rd_casc_out_n), .rd_data(rd_data), .cnt(lvl_cnt)
);

// File: tb/fifo_ring_slice_bench.sv
module fifo_ring_slice_bench;
  localparam int N = 3;
  localparam int D = 4;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [N-1:0] wco, rco, wr_rdy, rd_rdy;
  logic [W-1:0] rd_d [N];
  logic [W-1:0] rd_bus;
  logic         wr_any, rd_any;

  for (genvar g = 0; g < N; g++) begin : g_ring
    fifo_ring_slice #(.DEPTH(D), .WIDTH(W)) u_fifo_ring_slice (
      .clk(clk), .rst(rst), .standalone(1'b0), .first_load_n(g != 0),
      .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_rdy[g]),
      .rd_en(rd_en), .rd_data(rd_d[g]), .rd_ready(rd_rdy[g]),
      .wr_casc_in_n(wco[(g + N - 1) % N]), .wr_casc_out_n(wco[g]),
      .rd_casc_in_n(rco[(g + N - 1) % N]), .rd_casc_out_n(rco[g])
    );
  end

  always_comb begin
    rd_bus = '0;
    for (int s = 0; s < N; s++) rd_bus |= rd_d[s];
  end
  assign wr_any = |wr_rdy;
  assign rd_any = |rd_rdy;

  logic         s_wr_en = 1'b0, s_rd_en = 1'b0;
  logic [W-1:0] s_wd = '0, s_rd;
  logic         s_wr_rdy, s_rd_rdy, s_wco, s_rco;

  fifo_ring_slice #(.DEPTH(D), .WIDTH(W)) u_solo (
    .clk(clk), .rst(rst), .standalone(1'b1), .first_load_n(1'b0),
    .wr_en(s_wr_en), .wr_data(s_wd), .wr_ready(s_wr_rdy),
    .rd_en(s_rd_en), .rd_data(s_rd), .rd_ready(s_rd_rdy),
    .wr_casc_in_n(1'b1), .wr_casc_out_n(s_wco),
    .rd_casc_in_n(1'b1), .rd_casc_out_n(s_rco)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, wpulse = 0, rpulse = 0;
  logic [W-1:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: inputs change 1 ns after a rising edge; expected words queued.
  task automatic cyc(input bit w, input logic [W-1:0] d, input bit r);
    @(posedge clk); #1;
    if (w && wr_any) exp_q.push_back(d);
    wr_en = w; wr_data = d; rd_en = r;
  endtask

  // Monitor: samples at the falling edge, compares popped words.
  always @(negedge clk) begin
    if (!rst) begin
      for (int s = 0; s < N; s++) begin
        if (s != (rd_cnt / D) % N) chk(rd_d[s] == '0, "R6 idle bus", rd_d[s], 0);
        if (s != (wr_cnt / D) % N) chk(!wr_rdy[s], "R2 no token", wr_rdy[s], 0);
        if (!wco[s]) wpulse++;
        if (!rco[s]) rpulse++;
      end
      if (rd_en && rd_any) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 read beyond written", rd_bus, 0);
        else begin
          chk(rd_bus == exp_q[0], "R7 order", rd_bus, exp_q[0]);
          void'(exp_q.pop_front());
        end
        rd_cnt++;
      end
      if (wr_en && wr_any) wr_cnt++;
    end
  end

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  logic [W-1:0] sv [5];

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk(wr_rdy == 3'b001, "R1 write token", wr_rdy, 1);
    chk(rd_rdy == 3'b000, "R1 empty", rd_rdy, 0);
    chk(wco == 3'b111 && rco == 3'b111, "R1 cascade high", {wco, rco}, 6'h3f);
    chk(s_wco && s_rco && s_wr_rdy && !s_rd_rdy, "R1 solo reset", {s_wco, s_rco, s_wr_rdy, s_rd_rdy}, 4'b1110);

    // R3 R5: fill slice 0, watch the handoff
    for (int i = 0; i < D; i++) cyc(1'b1, W'(18'h1000 + i), 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(!wco[0], "R3 pulse low", wco[0], 0);
    chk(wr_rdy == 3'b010, "R5 token arrives same cycle", wr_rdy, 3'b010);
    chk(rd_rdy[0], "R6 holder ready", rd_rdy[0], 1);
    cyc(1'b0, '0, 1'b0);
    chk(wco[0], "R3 pulse one cycle", wco[0], 1);
    chk(wr_rdy == 3'b010, "R3 token kept by next", wr_rdy, 3'b010);

    // R7 fill ring, R8 writes on full ignored
    for (int i = D; i < D * N; i++) cyc(1'b1, W'(18'h1000 + i), 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(!wr_any, "R7 full after DEPTH*N", wr_any, 0);
    chk(exp_q.size() == D * N, "R7 depth", exp_q.size(), D * N);
    cyc(1'b1, 18'h3ffff, 1'b0);
    cyc(1'b1, 18'h3fffe, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(!wr_any, "R8 still full", wr_any, 0);

    // R4: drain, monitor checks order
    for (int i = 0; i < D * N; i++) cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b0);
    chk(exp_q.size() == 0 && !rd_any, "R7 drained", exp_q.size(), 0);
    chk(wr_rdy == 3'b001, "R3 token back to first", wr_rdy, 1);

    // R8 reads on empty ignored
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b1);
    cyc(1'b1, 18'h0abcd, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(rd_any && rd_bus == 18'h0abcd, "R8 empty read ignored", rd_bus, 18'h0abcd);
    cyc(1'b0, '0, 1'b1);

    // Mixed streaming, then concurrent traffic (R10)
    for (int i = 0; i < 60; i++) cyc((i % 4) != 3, W'(18'h2000 + i), (i >= 5) && (i % 3) != 1);
    for (int i = 0; i < 24; i++) cyc(1'b1, W'(18'h3000 + i), 1'b1);
    for (int i = 0; i < 20; i++) cyc(1'b1, W'(18'h4000 + i), 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(exp_q.size() == D * N && !wr_any, "R10 refill to full", exp_q.size(), D * N);
    for (int i = 0; i < D * N + 4; i++) cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(exp_q.size() == 0, "R7 final drain", exp_q.size(), 0);
    chk(wpulse == wr_cnt / D, "R3 write pulse count", wpulse, wr_cnt / D);
    chk(rpulse == rd_cnt / D, "R4 read pulse count", rpulse, rd_cnt / D);

    // R9 stand-alone slice
    for (int i = 0; i < 5; i++) sv[i] = W'(18'h5000 + 7 * i);
    @(posedge clk); #1 s_wr_en = 1'b1; s_wd = sv[0];
    @(posedge clk); #1 chk(s_wco, "R9 below half", s_wco, 1); s_wd = sv[1];
    @(posedge clk); #1 chk(!s_wco, "R9 half flag low", s_wco, 0); s_wd = sv[2];
    @(posedge clk); #1 s_wd = sv[3];
    @(posedge clk); #1 chk(!s_wr_rdy, "R9 solo full", s_wr_rdy, 0); s_wd = sv[4];
    @(posedge clk); #1 s_wr_en = 1'b0;
    chk(s_rco, "R9 read cascade high", s_rco, 1);
    s_rd_en = 1'b1;
    chk(s_rd == sv[0], "R9 solo head", s_rd, sv[0]);
    for (int i = 1; i < D; i++) begin
      @(posedge clk); #1 chk(s_rd == sv[i], "R9 solo order", s_rd, sv[i]);
    end
    @(posedge clk); #1 s_rd_en = 1'b0;
    chk(!s_rd_rdy, "R8 solo extra write ignored", s_rd_rdy, 0);
    chk(s_wco, "R9 half flag released", s_wco, 1);
    @(posedge clk); #1 s_wr_en = 1'b1; s_wd = 18'h0777;
    @(posedge clk); #1 s_wr_en = 1'b0;
    chk(s_rd_rdy && s_rd == 18'h0777, "R9 pointer wrap", s_rd, 18'h0777);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule